// File: doc/BRIEF.md
# Double Bus Fault Monitor

This block watches bus error events and sets them against the processor's exception flow. It decides whether an error becomes an ordinary bus error exception or a double fault that halts the processor for good. A bus error is held in a sticky latch and is acted on only at the next instruction boundary, so that several errors inside one instruction merge into a single exception request. Two windows count as fatal. The first runs from reset until the first instruction after reset executes. The second runs from the start of bus error exception entry until the first handler instruction executes. A bus error in either window halts the block, and only reset releases it.

Two side paths keep working in every state, including the halted one. Bus arbitration requests come back as grants one cycle later. Instruction prefetch data is forwarded one cycle later, and when a bus error ends the prefetch cycle the forwarded value is replaced by all ones. The prefetch path has no back-pressure: a beat is offered for exactly one cycle and the consumer must take it in that cycle. Every other pin is a plain level or a single-cycle pulse.

Top module: `bus_fault_monitor`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `halt_n_o` is 1 and `halted_o`, `exc_req_o`, `fetch_vld_o` and `arb_gnt_o` are all 0. Reset also opens the post-reset window.
- R2: A bus error in the post-reset window, in a cycle where `boot_first_i` is low, sets `halted_o` to 1 and `halt_n_o` to 0 from the next cycle.
- R3: A bus error outside the fatal windows does not raise `exc_req_o` on its own. `exc_req_o` rises in the cycle after an `insn_done_i` pulse, provided the latch is set or a bus error arrives in that same cycle.
- R4: Any number of bus errors before one instruction boundary give one request. `exc_req_o` stays high as a level and does not rise again until entry has started.
- R5: `exc_req_o` falls in the cycle after `exc_entry_i` is pulsed. That pulse also opens the entry window.
- R6: A bus error in the entry window, in a cycle where `hnd_first_i` is low, halts the block from the next cycle.
- R7: `hnd_first_i` clears the latch. After it, an `insn_done_i` pulse without a new bus error raises no request.
- R8: A bus error in the same cycle as `hnd_first_i` or `boot_first_i` is not a double fault. The latch stays set, so the next `insn_done_i` raises `exc_req_o`.
- R9: A bus error after the first handler instruction, or after the first post-reset instruction, never halts the block and raises an ordinary request.
- R10: Once halted, no input other than `rst_n` clears `halted_o` or raises `halt_n_o`.
- R11: Each bit of `arb_gnt_o` equals the same bit of `arb_req_i` from the previous cycle, in every state including the halted one.
- R12: `fetch_vld_o` is high for one cycle after each `fetch_end_i` pulse. `fetch_data_o` then carries `fetch_data_i` from that cycle, or all ones if `berr_i` was high in that cycle.
- R13: While halted, `exc_req_o` is 0. Instruction boundaries inside the entry window or the post-reset window raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| berr_i | input | 1 | Bus error strobe for the current cycle |
| insn_done_i | input | 1 | Pulse: an instruction completed |
| exc_entry_i | input | 1 | Pulse: bus error exception processing starts |
| hnd_first_i | input | 1 | Pulse: first handler instruction executed |
| boot_first_i | input | 1 | Pulse: first instruction after reset executed |
| fetch_end_i | input | 1 | Pulse: an instruction prefetch cycle terminates |
| fetch_data_i | input | DATA_W | Bus data at prefetch termination |
| arb_req_i | input | ARB_N | Bus arbitration requests |
| exc_req_o | output | 1 | Bus error exception request, level until entry |
| halt_n_o | output | 1 | Halt drive, active low |
| halted_o | output | 1 | Halted status |
| fetch_vld_o | output | 1 | Forwarded prefetch beat valid (one cycle) |
| fetch_data_o | output | DATA_W | Forwarded prefetch value |
| arb_gnt_o | output | ARB_N | Arbitration grants, one cycle behind requests |

## Verification
The assertions assume that the pulse inputs follow the exception flow. `exc_entry_i` comes only while a request is pending or just being raised, `hnd_first_i` only inside the entry window, and `boot_first_i` only inside the post-reset window. They also assume all inputs are low while reset is held. The bench drives each step from a known phase: it reaches each phase through a legal prefix and then applies every combination of the five control pulses for one cycle. Combinations that break the flow rules are included on purpose. The phase-local assertions still hold for them, because they only relate state to the next state.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,
    PH_RUN   = 2'd1,
    PH_ENTRY = 2'd2,
    PH_HALT  = 2'd3
  } phase_e;
endpackage

// File: rtl/bfm_phase_ctrl.sv
module bfm_phase_ctrl
  import bfm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   berr_i,
  input  logic   insn_done_i,
  input  logic   exc_entry_i,
  input  logic   hnd_first_i,
  input  logic   boot_first_i,
  output phase_e phase_o,
  output logic   pend_o
);
  phase_e phase_q, phase_d;
  logic   lat_q, lat_d;
  logic   pend_q, pend_d;

  always_comb begin
    phase_d = phase_q;
    lat_d   = lat_q;
    pend_d  = 1'b0;
    unique case (phase_q)
      PH_BOOT: begin
        if (boot_first_i) begin
          phase_d = PH_RUN;
          lat_d   = berr_i;        // coinciding error survives (R8)
        end else if (berr_i) begin
          phase_d = PH_HALT;       // error before first instruction (R2)
        end
      end
      PH_RUN: begin
        lat_d = lat_q | berr_i;
        if (exc_entry_i) begin
          phase_d = PH_ENTRY;
          pend_d  = 1'b0;
        end else begin
          pend_d = pend_q | (insn_done_i & (lat_q | berr_i));
        end
      end
      PH_ENTRY: begin
        if (hnd_first_i) begin
          phase_d = PH_RUN;
          lat_d   = berr_i;        // clear unless a new error lands now
        end else if (berr_i) begin
          phase_d = PH_HALT;       // second error during entry (R6)
        end
      end
      default: begin
        phase_d = PH_HALT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_BOOT;
      lat_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      lat_q   <= lat_d;
      pend_q  <= pend_d;
    end
  end

  assign phase_o = phase_q;
  assign pend_o  = pend_q;

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HALT) |=> (phase_q == PH_HALT));
  assert_boot_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BOOT && berr_i && !boot_first_i) |=> (phase_q == PH_HALT));
  assert_entry_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ENTRY && berr_i && !hnd_first_i) |=> (phase_q == PH_HALT));
  assert_late_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |=> (phase_q != PH_HALT));
  assert_req_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(insn_done_i));
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !exc_entry_i) |=> pend_q);
  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && exc_entry_i) |=> !pend_q);
  assert_no_req_halted_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HALT) |-> !pend_q);
endmodule

// File: rtl/bfm_fetch_sub.sv
module bfm_fetch_sub #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_end_i,
  input  logic              berr_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic              fetch_vld_o,
  output logic [DATA_W-1:0] fetch_data_o
);
  localparam logic [DATA_W-1:0] PRECHARGE = {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_vld_o  <= 1'b0;
      fetch_data_o <= '0;
    end else begin
      fetch_vld_o <= fetch_end_i;
      if (fetch_end_i) fetch_data_o <= berr_i ? PRECHARGE : fetch_data_i;
    end
  end

  assert_fetch_subst_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_end_i && berr_i) |=> (fetch_vld_o && fetch_data_o == PRECHARGE));
  assert_fetch_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_end_i |=> !fetch_vld_o);
endmodule

// File: rtl/bfm_arb_pass.sv
module bfm_arb_pass #(
  parameter int ARB_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ARB_N-1:0] arb_req_i,
  output logic [ARB_N-1:0] arb_gnt_o
);
  for (genvar g = 0; g < ARB_N; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) arb_gnt_o[g] <= 1'b0;
      else        arb_gnt_o[g] <= arb_req_i[g];
    end

    assert_gnt_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (arb_gnt_o[g] == $past(arb_req_i[g])));
  end
endmodule

// File: rtl/bus_fault_monitor.sv
module bus_fault_monitor
  import bfm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ARB_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              berr_i,
  input  logic              insn_done_i,
  input  logic              exc_entry_i,
  input  logic              hnd_first_i,
  input  logic              boot_first_i,
  input  logic              fetch_end_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  input  logic [ARB_N-1:0]  arb_req_i,
  output logic              exc_req_o,
  output logic              halt_n_o,
  output logic              halted_o,
  output logic              fetch_vld_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic [ARB_N-1:0]  arb_gnt_o
);
  phase_e phase;
  logic   pend;

  bfm_phase_ctrl u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .berr_i       (berr_i),
    .insn_done_i  (insn_done_i),
    .exc_entry_i  (exc_entry_i),
    .hnd_first_i  (hnd_first_i),
    .boot_first_i (boot_first_i),
    .phase_o      (phase),
    .pend_o       (pend)
  );

  bfm_fetch_sub #(.DATA_W(DATA_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_end_i  (fetch_end_i),
    .berr_i       (berr_i),
    .fetch_data_i (fetch_data_i),
    .fetch_vld_o  (fetch_vld_o),
    .fetch_data_o (fetch_data_o)
  );

  bfm_arb_pass #(.ARB_N(ARB_N)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_req_i (arb_req_i),
    .arb_gnt_o (arb_gnt_o)
  );

  assign halted_o  = (phase == PH_HALT);
  assign halt_n_o  = ~halted_o;
  assign exc_req_o = pend;

  assert_pins_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> (!halt_n_o && halted_o));
  assert_halt_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n_o |-> !exc_req_o);
endmodule

// File: tb/tb_bus_fault_monitor.sv
module tb_bus_fault_monitor;
  localparam int DATA_W = 8;
  localparam int ARB_N  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic berr_i = 0, insn_done_i = 0, exc_entry_i = 0, hnd_first_i = 0, boot_first_i = 0;
  logic fetch_end_i = 0;
  logic [DATA_W-1:0] fetch_data_i = '0;
  logic [ARB_N-1:0]  arb_req_i = '0;
  logic exc_req_o, halt_n_o, halted_o, fetch_vld_o;
  logic [DATA_W-1:0] fetch_data_o;
  logic [ARB_N-1:0]  arb_gnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model: phase 0 boot, 1 run, 2 entry, 3 halted
  int m_ph;
  bit m_lat, m_pend;

  always #2.5 clk = ~clk;

  bus_fault_monitor #(.DATA_W(DATA_W), .ARB_N(ARB_N)) dut (
    .clk(clk), .rst_n(rst_n), .berr_i(berr_i), .insn_done_i(insn_done_i),
    .exc_entry_i(exc_entry_i), .hnd_first_i(hnd_first_i), .boot_first_i(boot_first_i),
    .fetch_end_i(fetch_end_i), .fetch_data_i(fetch_data_i), .arb_req_i(arb_req_i),
    .exc_req_o(exc_req_o), .halt_n_o(halt_n_o), .halted_o(halted_o),
    .fetch_vld_o(fetch_vld_o), .fetch_data_o(fetch_data_o), .arb_gnt_o(arb_gnt_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // v[0] berr, v[1] insn_done, v[2] exc_entry, v[3] hnd_first, v[4] boot_first
  task automatic model(input logic [4:0] v);
    bit b, ins, en, hf, bf;
    {bf, hf, en, ins, b} = v;
    case (m_ph)
      0: if (bf) begin m_ph = 1; m_lat = b; end
         else if (b) m_ph = 3;
      1: begin
           if (en) begin m_ph = 2; m_pend = 0; end
           else if (ins && (m_lat || b)) m_pend = 1;
           m_lat = m_lat | b;
         end
      2: if (hf) begin m_ph = 1; m_lat = b; end
         else if (b) m_ph = 3;
      default: m_pend = 0;
    endcase
    if (m_ph != 1) m_pend = 0;
  endtask

  task automatic drive(input logic [4:0] v);
    {boot_first_i, hnd_first_i, exc_entry_i, insn_done_i, berr_i} = v;
    @(posedge clk); #1;
    {boot_first_i, hnd_first_i, exc_entry_i, insn_done_i, berr_i} = '0;
    model(v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {boot_first_i, hnd_first_i, exc_entry_i, insn_done_i, berr_i} = '0;
    fetch_end_i = 0; arb_req_i = '0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
    m_ph = 0; m_lat = 0; m_pend = 0;
  endtask

  task automatic prefix(input int p);
    do_reset();
    case (p)
      1: drive(5'b10000);
      2: begin drive(5'b10000); drive(5'b00001); end
      3: begin drive(5'b10000); drive(5'b00001); drive(5'b00010); end
      4: begin drive(5'b10000); drive(5'b00001); drive(5'b00010); drive(5'b00100); end
      5: drive(5'b00001);
      default: ;
    endcase
  endtask

  function automatic string tag_of(input int p);
    case (p)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    // R1: reset values
    rst_n = 0;
    @(posedge clk); #1;
    chk("R1", "halt_n in reset", halt_n_o, 1);
    chk("R1", "halted in reset", halted_o, 0);
    do_reset();
    chk("R1", "exc_req after reset", exc_req_o, 0);
    chk("R1", "fetch_vld after reset", fetch_vld_o, 0);
    chk("R1", "arb_gnt after reset", arb_gnt_o, 0);

    // Sweep: every pulse combination from every phase
    for (int p = 0; p < 6; p++) begin
      for (int v = 0; v < 32; v++) begin
        prefix(p);
        drive(v[4:0]);
        chk(tag_of(p), $sformatf("halted p=%0d v=%0d", p, v), halted_o, (m_ph == 3) ? 1 : 0);
        chk(tag_of(p), $sformatf("halt_n p=%0d v=%0d", p, v), halt_n_o, (m_ph == 3) ? 0 : 1);
        chk((p == 5) ? "R13" : tag_of(p), $sformatf("exc_req p=%0d v=%0d", p, v), exc_req_o, m_pend);
        drive(5'b00010); // probe latch via instruction boundary (R7)
        chk("R7", $sformatf("probe exc_req p=%0d v=%0d", p, v), exc_req_o, m_pend);
      end
    end

    // R8: error coinciding with handler first instruction
    prefix(4);
    drive(5'b01001);
    chk("R8", "no halt on coincident error", halted_o, 0);
    drive(5'b00010);
    chk("R8", "coincident error kept", exc_req_o, 1);

    // R7 and R9: clean handler entry, then a late error
    prefix(4);
    drive(5'b01000);
    drive(5'b00010);
    chk("R7", "latch cleared", exc_req_o, 0);
    drive(5'b00001);
    drive(5'b00010);
    chk("R9", "late error is ordinary", exc_req_o, 1);
    chk("R9", "late error no halt", halted_o, 0);

    // R4: many errors, single level request until entry
    prefix(2);
    drive(5'b00001); drive(5'b00011);
    chk("R4", "request raised", exc_req_o, 1);
    drive(5'b00011);
    chk("R4", "request held", exc_req_o, 1);
    drive(5'b00100);
    chk("R5", "request dropped on entry", exc_req_o, 0);
    drive(5'b00010);
    chk("R13", "no request in entry window", exc_req_o, 0);

    // R10: halted stays through all pulses, reset releases
    prefix(5);
    for (int v = 0; v < 32; v++) drive(v[4:0]);
    chk("R10", "still halted", halted_o, 1);
    do_reset();
    chk("R10", "reset releases", halted_o, 0);

    // R11: arbitration while halted
    prefix(5);
    arb_req_i = 2'b10;
    @(posedge clk); #1;
    chk("R11", "grant while halted", arb_gnt_o, 2);
    arb_req_i = 2'b01;
    @(posedge clk); #1;
    chk("R11", "grant follows", arb_gnt_o, 1);
    arb_req_i = '0;

    // R12: prefetch forwarding and substitution
    do_reset();
    for (int d = 0; d < 256; d += 37) begin
      for (int e = 0; e < 2; e++) begin
        fetch_end_i = 1; fetch_data_i = d[7:0]; berr_i = e[0];
        @(posedge clk); #1;
        fetch_end_i = 0; berr_i = 0;
        chk("R12", "fetch valid", fetch_vld_o, 1);
        chk("R12", $sformatf("fetch data d=%0d e=%0d", d, e), fetch_data_o, (e == 1) ? 255 : d);
        @(posedge clk); #1;
        chk("R12", "fetch valid one cycle", fetch_vld_o, 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule